// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Registered Status Flags

This block is a combinational arithmetic and logic unit that adds, subtracts, ANDs, ORs or XORs two operands of a parameterised width (8, 16 or 32 bits). Its result appears on the output in the same cycle. Next to the result it forms six status flags: carry, overflow, sign, zero, nibble carry and parity. These flags are captured into registers at the clock edge on which the strobe input is high. On every other edge they keep their last value.

A surrounding datapath presents operands and an operation code, reads the result at once, and pulses the strobe when that result should become the current condition state. Later compare or branch logic then reads the six flag outputs until the next strobe. The operation code is 3 bits wide: 000 add, 001 subtract, 010 AND, 011 OR, 100 XOR. Codes 101 to 111 are reserved.

Top module: `alu_flag_unit`

## Requirements
- R1: For op 000 the result is (a + b) mod 2^W, and after a strobe the carry flag is 1 exactly when the unsigned sum exceeds 2^W - 1.
- R2: For op 001 the result is (a - b) mod 2^W, and after a strobe the carry flag is 1 exactly when a < b as unsigned numbers (a borrow).
- R3: After a strobed add or subtract, the overflow flag is 1 exactly when the signed two's-complement result of the operation lies outside the range of a W-bit signed number.
- R4: After any strobed operation with op 000 to 100, the sign flag equals the most significant bit (bit W-1) of the result.
- R5: After any strobed operation with op 000 to 100, the zero flag is 1 exactly when all W bits of the result are 0.
- R6: After a strobed add, the nibble-carry flag is 1 exactly when a[3:0] + b[3:0] > 15. After a strobed subtract, it is 1 exactly when a[3:0] < b[3:0].
- R7: After any strobed operation with op 000 to 100, the parity flag is 1 exactly when result bits [7:0] hold an even number of ones.
- R8: For op 010, 011 and 100 the result is a & b, a | b and a ^ b. After a strobe the carry, overflow and nibble-carry flags are 0.
- R9: While the strobe is low, all six flags keep their values across clock edges, while the result still follows the inputs.
- R10: While the active-low reset is asserted, all six flags are 0.
- R11: For the reserved op codes 101, 110 and 111 the result is 0, and the flags keep their values even when the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag registers |
| valid | input | 1 | Strobe: capture flags at this edge |
| op | input | 3 | Operation code |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | W | Combinational result |
| flag_carry | output | 1 | Unsigned carry or borrow |
| flag_parity | output | 1 | Even parity of result bits [7:0] |
| flag_nibble | output | 1 | Carry or borrow between bits 3 and 4 |
| flag_zero | output | 1 | Result is all zeros |
| flag_sign | output | 1 | Most significant bit of the result |
| flag_ovf | output | 1 | Signed overflow |

## Verification
The only internal state is the six flag registers. A wrong value in any of them shows on its port one cycle after the strobe that loaded it, and it stays visible until the next strobe. A flag register that loads when it should hold shows up on the first unstrobed edge or the first strobed reserved code, because the flags then change. Errors in the combinational result show on the result port in the same cycle as the inputs, before any edge.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         flag_carry,
  output logic         flag_parity,
  output logic         flag_nibble,
  output logic         flag_zero,
  output logic         flag_sign,
  output logic         flag_ovf
);
  localparam int MSB = W - 1;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  logic [W:0] sum_w, dif_w;
  logic       is_arith, is_legal;
  logic       nxt_c, nxt_a, nxt_o;

  assign sum_w = {1'b0, a} + {1'b0, b};
  assign dif_w = {1'b0, a} - {1'b0, b};

  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign is_legal = (op <= OP_XOR);

  always_comb begin
    case (op)
      OP_ADD:  result = sum_w[W-1:0];
      OP_SUB:  result = dif_w[W-1:0];
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      default: result = '0;
    endcase
  end

  assign nxt_c = (op == OP_ADD) ? sum_w[W] : (op == OP_SUB) ? dif_w[W] : 1'b0;
  assign nxt_a = is_arith & (a[4] ^ b[4] ^ result[4]);
  assign nxt_o = (op == OP_ADD) ? ((a[MSB] == b[MSB]) && (result[MSB] != a[MSB])) :
                 (op == OP_SUB) ? ((a[MSB] != b[MSB]) && (result[MSB] != a[MSB])) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_carry  <= 1'b0;
      flag_parity <= 1'b0;
      flag_nibble <= 1'b0;
      flag_zero   <= 1'b0;
      flag_sign   <= 1'b0;
      flag_ovf    <= 1'b0;
    end else if (valid && is_legal) begin
      flag_carry  <= nxt_c;
      flag_parity <= ~^result[7:0];
      flag_nibble <= nxt_a;
      flag_zero   <= (result == '0);
      flag_sign   <= result[MSB];
      flag_ovf    <= nxt_o;
    end
  end

  assert_add_top_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == OP_ADD && a[MSB] && b[MSB] |=> flag_carry);
  assert_sub_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == OP_SUB && a == b |=> flag_zero && !flag_carry && !flag_ovf);
  assert_zero_not_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_zero |-> !flag_sign);
  assert_zero_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_legal && result == '0 |=> flag_zero && flag_parity);
  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op >= OP_AND && op <= OP_XOR |=> !flag_carry && !flag_ovf && !flag_nibble);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable({flag_carry, flag_parity, flag_nibble, flag_zero, flag_sign, flag_ovf}));
  assert_reserved_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op > OP_XOR |=> $stable({flag_carry, flag_parity, flag_nibble, flag_zero, flag_sign, flag_ovf}));
endmodule

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [2:0]   op = 3'd0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] result;
  logic fc, fp, fa, fz, fs, fo;

  int checks = 0, fails = 0;
  logic [5:0] exp_flags = 6'b0;   // {c,p,a,z,s,o}

  alu_flag_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .a(a), .b(b),
    .result(result), .flag_carry(fc), .flag_parity(fp), .flag_nibble(fa),
    .flag_zero(fz), .flag_sign(fs), .flag_ovf(fo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (op %0d a %h b %h)", tag, act, exp, op, a, b);
    end
  endtask

  function automatic logic [W-1:0] ref_res(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    case (o)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      default: return '0;
    endcase
  endfunction

  function automatic logic [5:0] ref_flags(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    longint sx, sy, sr, smax, smin;
    logic c, p, n, z, s, v;
    r = ref_res(o, x, y);
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    smax = (longint'(1) <<< (W-1)) - 1;
    smin = -(longint'(1) <<< (W-1));
    c = 0; n = 0; v = 0;
    if (o == 3'd0) begin
      c = (longint'(x) + longint'(y)) > ((longint'(1) <<< W) - 1);
      n = (x[3:0] + 5'd0 + y[3:0]) > 5'd15;
      sr = sx + sy; v = (sr > smax) || (sr < smin);
    end else if (o == 3'd1) begin
      c = x < y;
      n = x[3:0] < y[3:0];
      sr = sx - sy; v = (sr > smax) || (sr < smin);
    end
    p = ($countones(r[7:0]) % 2) == 0;
    z = (r == '0);
    s = r[W-1];
    return {c, p, n, z, s, v};
  endfunction

  function automatic string res_tag(input logic [2:0] o);
    return (o == 3'd0) ? "R1" : (o == 3'd1) ? "R2" : (o <= 3'd4) ? "R8" : "R11";
  endfunction

  task automatic check_flags(input string ctx);
    logic [5:0] act;
    act = {fc, fp, fa, fz, fs, fo};
    chk({ctx, " carry R1 R2 R8"}, W'(act[5]), W'(exp_flags[5]));
    chk({ctx, " parity R7"},      W'(act[4]), W'(exp_flags[4]));
    chk({ctx, " nibble R6 R8"},   W'(act[3]), W'(exp_flags[3]));
    chk({ctx, " zero R5"},        W'(act[2]), W'(exp_flags[2]));
    chk({ctx, " sign R4"},        W'(act[1]), W'(exp_flags[1]));
    chk({ctx, " overflow R3 R8"}, W'(act[0]), W'(exp_flags[0]));
  endtask

  task automatic run(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    valid = 1'b1; op = o; a = x; b = y;
    #1 chk(res_tag(o), result, ref_res(o, x, y));
    if (o <= 3'd4) exp_flags = ref_flags(o, x, y);
    @(negedge clk);
    valid = 1'b0;
    check_flags(o <= 3'd4 ? "strobed" : "reserved R11");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R10: reset clears flags
    repeat (2) @(negedge clk);
    check_flags("reset R10");
    rst_n = 1'b1;

    // directed corners
    run(3'd0, 16'hFFFF, 16'h0001);   // R1 carry, zero, nibble
    run(3'd0, 16'h7FFF, 16'h0001);   // R3 positive overflow
    run(3'd0, 16'h8000, 16'h8000);   // R1 R3 carry and overflow, zero
    run(3'd1, 16'h0000, 16'h0001);   // R2 borrow, R6 nibble borrow
    run(3'd1, 16'h8000, 16'h0001);   // R3 negative overflow
    run(3'd1, 16'h1234, 16'h1234);   // R5 zero
    run(3'd0, 16'h000F, 16'h0001);   // R6 nibble carry only
    run(3'd2, 16'hF0F0, 16'h0FF0);   // R8
    run(3'd3, 16'h8000, 16'h0003);   // R8 R4
    run(3'd4, 16'hAAAA, 16'hAAAA);   // R8 zero
    run(3'd0, 16'h0100, 16'h0000);   // R7 parity low byte only
    run(3'd4, 16'h0000, 16'h0007);   // R7 odd parity

    // R11: reserved codes after a flag-setting op
    run(3'd0, 16'hFFFF, 16'h0001);
    for (int k = 5; k < 8; k++) run(3'(k), 16'h1234, 16'h00FF);

    // R9: hold while strobe low, result still live
    run(3'd1, 16'h0000, 16'h0005);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op = 3'd0; a = 16'(k); b = 16'h0000;
      #1 chk("idle result R9", result, 16'(k));
      @(negedge clk);
      check_flags("idle hold R9");
    end

    // random
    for (int k = 0; k < 300; k++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 5));
      run(o, W'($urandom), W'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule